// File: doc/BRIEF.md
# Memory-Mapped Serial Port with Character FIFOs

This block is a complete asynchronous serial port. Software reaches it through a small word-addressed register bus. Characters written to the transmit register enter a 32-entry transmit queue. A shifter sends them on `txd`, least significant bit first, as frames of one start bit, eight data bits and one stop bit. The receiver watches `rxd`. It finds each start edge and samples every bit at its middle. Each completed character goes into a 32-entry receive queue, which software drains by reading the receive register.

Line faults are kept as sticky error flags in the status register, and software clears them by writing ones. The flags cover a break, a bad stop bit and a character lost to a full receive queue. Two level outputs, one for receive and one for transmit, combine the status with enable bits in the control register.

A 10-bit divisor sets the rate. One bit lasts divisor × 16 clock cycles. The oversampling register is kept for software but does not change the rate.

Top module: `uart_mmio`

## Requirements
- R1: After reset, the control, divisor and oversampling registers read 0. Status reads 0x0000_2060 (bits 13, 6 and 5 set). `txd` is high and both interrupt outputs are low.
- R2: Each transmitted character appears on `txd` as one low start bit, eight data bits LSB first and one high stop bit. Every bit lasts divisor × 16 cycles.
- R3: The transmit queue (write to address 0x04) holds 32 characters. When it holds 32, status bit 11 is 1 and status bit 5 is 0, and a further write is discarded. Status bit 13 is 1 only when the queue is empty.
- R4: A character received on `rxd` is returned in bits 7:0 of a read at address 0x00, in arrival order. The read removes it. Status bit 4 is 1 while the receive queue is not empty.
- R5: A character that completes while the receive queue holds 32 sets status bit 0 and is discarded.
- R6: A frame whose start, data and stop samples are all low sets status bit 3. It stores no character and does not set status bit 2.
- R7: A frame with a low stop bit and nonzero data sets status bit 2. The character is still stored.
- R8: Status bits 3:0 stay set until a write to address 0x0C puts a 1 in that bit position. Writing 0 leaves them unchanged. Bit 1 never sets, because the frame carries no parity.
- R9: `irq_rx` is high when (status bit 4 and control bit 4) or any status bit i in 3:0 together with control bit i. `irq_tx` is high when control bit 5 is set and the transmit queue is not full.
- R10: While control bit 11 is set, `txd` is held low.
- R11: Writing control with bit 15 set empties the transmit queue. Writing control with bit 14 set empties the receive queue. Neither bit is stored.
- R12: Writing control with bit 31 set returns control, divisor, status flags and both queues to their reset state. The oversampling register keeps its value. The oversampling register reads back the written value masked by 0x3F3F3F3F.
- R13: The divisor register (address 0x10) keeps bits 9:0 of the written value. A divisor below 2 stops the rate generator, so nothing is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops the receive queue at 0x00) |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle the address is presented |
| rxd | input | 1 | Serial input line |
| txd | output | 1 | Serial output line |
| irq_rx | output | 1 | Receive-side interrupt level |
| irq_tx | output | 1 | Transmit-side interrupt level |

## Verification
With the output looped back to the input, 32 distinct characters are queued while the divisor is zero and then sent back to back. This one pattern tests queue capacity, line framing and receive ordering, and it shows that the extra character was dropped. One all-zero character is timed on the line, which separates a correct bit period from one that is off by a tick. The same character then arrives at a full receive queue and must raise the overrun flag. With the loop opened, hand-made frames are driven: a long low period, a bad stop bit and a good frame. These separate break from framing error, and they test the clear-by-one rule one bit at a time, the interrupt enables and both queue flushes.

// File: rtl/uart_mmio.sv
module uart_mmio #(
  parameter int DEPTH = 32,
  parameter int DIV_W = 10,
  parameter int OS    = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [4:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        rxd,
  output logic        txd,
  output logic        irq_rx,
  output logic        irq_tx
);
  localparam int AW = $clog2(DEPTH);
  localparam int OW = $clog2(OS);
  localparam logic [AW:0] FULLC = (AW+1)'(DEPTH);

  logic [31:0] ctrl, osamp;
  logic [DIV_W-1:0] div, bcnt;
  logic [3:0] err;
  logic [7:0] tx_mem [DEPTH];
  logic [7:0] rx_mem [DEPTH];
  logic [AW:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic tx_busy, rx_busy;
  logic [9:0] tx_sh;
  logic [3:0] tx_n, rx_n;
  logic [OW-1:0] tx_os, rx_os;
  logic [7:0] rx_sh;
  logic [2:0] rx_s;

  wire wr_tx  = bus_wr && bus_addr == 5'h04;
  wire wr_ctl = bus_wr && bus_addr == 5'h08;
  wire wr_st  = bus_wr && bus_addr == 5'h0C;
  wire wr_div = bus_wr && bus_addr == 5'h10;
  wire wr_os  = bus_wr && bus_addr == 5'h14;
  wire clr    = !rst_n || (wr_ctl && bus_wdata[31]);
  wire tx_fl  = wr_ctl && bus_wdata[15];
  wire rx_fl  = wr_ctl && bus_wdata[14];

  wire [AW:0] tx_cnt = tx_wp - tx_rp;
  wire [AW:0] rx_cnt = rx_wp - rx_rp;
  wire tx_full  = tx_cnt == FULLC;
  wire tx_empty = tx_cnt == '0;
  wire rx_full  = rx_cnt == FULLC;
  wire rx_empty = rx_cnt == '0;

  wire tick    = div >= DIV_W'(2) && bcnt == div - DIV_W'(1);
  wire rx_now  = rx_s[1];
  wire rx_prev = rx_s[2];
  wire tx_push = wr_tx && !tx_full;
  wire tx_pop  = tick && !tx_busy && !tx_empty;
  wire rx_pop  = bus_rd && bus_addr == 5'h00 && !rx_empty;
  wire rx_done = rx_busy && tick && rx_n == 4'd9 && rx_os == OW'(OS-1);
  wire rx_brk  = rx_done && !rx_now && rx_sh == 8'h00;
  wire rx_good = rx_done && !rx_brk;
  wire rx_push = rx_good && !rx_full;

  always_ff @(posedge clk) begin
    if (clr) begin
      ctrl <= '0; div <= '0; bcnt <= '0; err <= '0;
      tx_wp <= '0; tx_rp <= '0; rx_wp <= '0; rx_rp <= '0;
      tx_busy <= 1'b0; tx_sh <= '1; tx_n <= '0; tx_os <= '0;
      rx_busy <= 1'b0; rx_n <= '0; rx_os <= '0; rx_sh <= '0; rx_s <= '1;
    end else begin
      if (wr_ctl) ctrl <= bus_wdata & 32'h0000_083F;
      if (wr_div) div <= bus_wdata[DIV_W-1:0];
      bcnt <= (wr_div || tick || div < DIV_W'(2)) ? '0 : bcnt + DIV_W'(1);

      if (tx_fl) begin
        tx_wp <= '0; tx_rp <= '0;
      end else begin
        if (tx_push) tx_wp <= tx_wp + 1'b1;
        if (tx_pop)  tx_rp <= tx_rp + 1'b1;
      end
      if (rx_fl) begin
        rx_wp <= '0; rx_rp <= '0;
      end else begin
        if (rx_push) rx_wp <= rx_wp + 1'b1;
        if (rx_pop)  rx_rp <= rx_rp + 1'b1;
      end

      err <= (err & ~(wr_st ? bus_wdata[3:0] : 4'h0)) |
             {rx_brk, rx_good && !rx_now, 1'b0, rx_good && rx_full};

      if (tx_pop) begin
        tx_busy <= 1'b1;
        tx_sh   <= {1'b1, tx_mem[tx_rp[AW-1:0]], 1'b0};
        tx_n    <= '0;
        tx_os   <= '0;
      end else if (tx_busy && tick) begin
        tx_os <= tx_os + 1'b1;
        if (tx_os == OW'(OS-1)) begin
          tx_sh <= {1'b1, tx_sh[9:1]};
          tx_n  <= tx_n + 1'b1;
          if (tx_n == 4'd9) tx_busy <= 1'b0;
        end
      end

      rx_s <= {rx_s[1:0], rxd};
      if (!rx_busy) begin
        if (rx_prev && !rx_now) begin
          rx_busy <= 1'b1; rx_n <= '0; rx_os <= '0;
        end
      end else if (tick) begin
        rx_os <= rx_os + 1'b1;
        if (rx_n == 4'd0 && rx_os == OW'(OS/2-1)) begin
          if (rx_now) rx_busy <= 1'b0;
          else begin rx_n <= 4'd1; rx_os <= '0; end
        end else if (rx_n != 4'd0 && rx_os == OW'(OS-1)) begin
          rx_os <= '0;
          rx_n  <= rx_n + 1'b1;
          if (rx_n == 4'd9) rx_busy <= 1'b0;
          else rx_sh <= {rx_now, rx_sh[7:1]};
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (tx_push) tx_mem[tx_wp[AW-1:0]] <= bus_wdata[7:0];
    if (rx_push) rx_mem[rx_wp[AW-1:0]] <= rx_sh;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) osamp <= '0;
    else if (wr_os) osamp <= bus_wdata & 32'h3F3F_3F3F;
  end

  wire [31:0] status = {18'b0, tx_empty, 1'b0, tx_full, 4'b0,
                        !tx_busy && tx_empty, !tx_full, !rx_empty, err};

  always_comb begin
    case (bus_addr)
      5'h00:   bus_rdata = {24'b0, rx_mem[rx_rp[AW-1:0]]};
      5'h08:   bus_rdata = ctrl;
      5'h0C:   bus_rdata = status;
      5'h10:   bus_rdata = {{(32-DIV_W){1'b0}}, div};
      5'h14:   bus_rdata = osamp;
      default: bus_rdata = '0;
    endcase
  end

  assign txd    = !ctrl[11] && (tx_busy ? tx_sh[0] : 1'b1);
  assign irq_rx = (ctrl[4] && !rx_empty) || |(err & ctrl[3:0]);
  assign irq_tx = ctrl[5] && !tx_full;

  assert_tx_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= FULLC);
  assert_rx_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt <= FULLC);
  assert_ovr_only_when_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err[0]) |-> $past(rx_cnt) == FULLC);
  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_st || clr) |=> (err & $past(err)) == $past(err));
  assert_brk_line_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctl && bus_wdata[11] && !bus_wdata[31] |=> !txd);
endmodule

// File: tb/uart_mmio_tb.sv
`timescale 1ns/1ps
module uart_mmio_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [4:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic txd, irq_rx, irq_tx;
  logic loop = 1'b0, drv = 1'b1, mon_en = 1'b0;
  int n_chk = 0, n_fail = 0, mon_cnt = 0;
  int bp = 32;
  logic [7:0] exp_q[$];
  logic [7:0] fill[32];
  wire rxd_w = loop ? txd : drv;

  always #2.5 clk = ~clk;

  uart_mmio u_dut (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rxd(rxd_w), .txd(txd), .irq_rx(irq_rx), .irq_tx(irq_tx));

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic tx_write(input logic [7:0] b, input bit expect_it);
    if (expect_it) exp_q.push_back(b);
    wr(5'h04, {24'b0, b});
  endtask

  task automatic send_rx(input logic [7:0] b, input logic stop);
    drv = 1'b0; repeat (bp) @(negedge clk);
    for (int i = 0; i < 8; i++) begin drv = b[i]; repeat (bp) @(negedge clk); end
    drv = stop; repeat (bp) @(negedge clk);
    drv = 1'b1; repeat (2*bp) @(negedge clk);
  endtask

  task automatic send_break();
    drv = 1'b0; repeat (12*bp) @(negedge clk);
    drv = 1'b1; repeat (2*bp) @(negedge clk);
  endtask

  task automatic wait_tx_idle();
    logic [31:0] s;
    for (int i = 0; i < 20000; i++) begin
      rd(5'h0C, s);
      if (s[6]) break;
    end
    repeat (8) @(negedge clk);
  endtask

  // Monitor: decodes txd independently and pops the scoreboard
  initial begin
    logic [7:0] mb;
    logic [7:0] e;
    logic st, sp;
    forever begin
      @(negedge clk);
      if (mon_en && txd === 1'b0) begin
        repeat (bp/2) @(negedge clk);
        st = txd;
        for (int i = 0; i < 8; i++) begin repeat (bp) @(negedge clk); mb[i] = txd; end
        repeat (bp) @(negedge clk);
        sp = txd;
        mon_cnt++;
        check(st == 1'b0 && sp == 1'b1, "R2 framing on txd", {30'b0, st, sp}, 32'h1);
        if (exp_q.size() == 0) check(1'b0, "R2 unexpected char", {24'b0, mb}, 32'h0);
        else begin
          e = exp_q.pop_front();
          check(mb == e, "R2 char on txd", {24'b0, mb}, {24'b0, e});
        end
      end
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog expired", 32'h0, 32'h0);
    finish_run();
  end

  initial begin
    logic [31:0] d;
    int lowc;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(5'h0C, d); check(d == 32'h0000_2060, "R1 status", d, 32'h0000_2060);
    rd(5'h08, d); check(d == 0, "R1 control", d, 0);
    rd(5'h14, d); check(d == 0, "R1 oversampling", d, 0);
    check(txd == 1'b1 && irq_rx == 1'b0 && irq_tx == 1'b0, "R1 lines",
          {29'b0, txd, irq_rx, irq_tx}, 32'h4);

    // R13 divisor width
    wr(5'h10, 32'hFFFF_FFFF); rd(5'h10, d); check(d == 32'h3FF, "R13 divisor mask", d, 32'h3FF);
    wr(5'h10, 32'h0);

    // R3 fill queue with generator stopped
    loop = 1'b1; mon_en = 1'b1;
    for (int i = 0; i < 32; i++) begin fill[i] = 8'h40 + 8'(i*7); tx_write(fill[i], 1'b1); end
    rd(5'h0C, d); check(d[11] && !d[5] && !d[13], "R3 full flags", d, 32'h800);
    tx_write(8'hEE, 1'b0);
    repeat (100) @(negedge clk);
    check(txd == 1'b1 && mon_cnt == 0, "R13 stalled with divisor 0", {31'b0, txd}, 32'h1);

    // R2 / R4 drain at divisor 2
    wr(5'h10, 32'd2);
    wait_tx_idle();
    check(mon_cnt == 32 && exp_q.size() == 0, "R3 exactly 32 sent", mon_cnt, 32);
    rd(5'h0C, d); check(d[4] && d[3:0] == 0, "R4 rx ready", d, 32'h10);

    // R2 bit period and R5 overrun with an all-zero char
    tx_write(8'h00, 1'b1);
    while (txd == 1'b1) @(negedge clk);
    lowc = 0;
    while (txd == 1'b0) begin lowc++; @(negedge clk); end
    check(lowc == 9*bp, "R2 bit period", lowc, 9*bp);
    wait_tx_idle();
    rd(5'h0C, d); check(d[0] == 1'b1, "R5 overrun flag", d, 32'h1);
    for (int i = 0; i < 32; i++) begin
      rd(5'h00, d);
      check(d == {24'b0, fill[i]}, "R4 rx order", d, {24'b0, fill[i]});
    end
    rd(5'h0C, d); check(!d[4], "R5 dropped char absent", d, 32'h0);

    // R8 clear by one
    wr(5'h0C, 32'h0); rd(5'h0C, d); check(d[0], "R8 zero write keeps", d, 32'h1);
    wr(5'h0C, 32'h1); rd(5'h0C, d); check(d[3:0] == 0, "R8 clear overrun", d, 32'h0);

    // R6 break
    loop = 1'b0; mon_en = 1'b0;
    send_break();
    rd(5'h0C, d); check(d[3] && !d[2] && !d[4], "R6 break only", d, 32'h8);

    // R7 framing error, char kept
    send_rx(8'h5A, 1'b0);
    rd(5'h0C, d); check(d[2] && d[4], "R7 framing flag", d, 32'h1C);
    rd(5'h00, d); check(d == 32'h5A, "R7 char kept", d, 32'h5A);
    wr(5'h0C, 32'h4); rd(5'h0C, d); check(!d[2] && d[3], "R8 single bit clear", d, 32'h8);
    wr(5'h0C, 32'h8); rd(5'h0C, d); check(d[3:0] == 0, "R8 break clear", d, 32'h0);

    // R9 interrupts
    wr(5'h08, 32'h3F);
    check(irq_tx && !irq_rx, "R9 idle irqs", {30'b0, irq_rx, irq_tx}, 32'h1);
    send_rx(8'h3C, 1'b1);
    check(irq_rx, "R9 rx ready irq", {31'b0, irq_rx}, 32'h1);
    rd(5'h00, d); check(d == 32'h3C, "R4 good frame", d, 32'h3C);
    check(!irq_rx, "R9 irq drops after read", {31'b0, irq_rx}, 32'h0);
    wr(5'h08, 32'h08);
    check(!irq_tx, "R9 tx enable off", {31'b0, irq_tx}, 32'h0);
    send_break();
    check(irq_rx, "R9 break irq", {31'b0, irq_rx}, 32'h1);
    wr(5'h0C, 32'hF);
    check(!irq_rx, "R9 irq after clear", {31'b0, irq_rx}, 32'h0);

    // R10 break on line
    wr(5'h08, 32'h800); check(txd == 1'b0, "R10 line held low", {31'b0, txd}, 32'h0);
    wr(5'h08, 32'h0);   check(txd == 1'b1, "R10 line released", {31'b0, txd}, 32'h1);

    // R11 flushes
    wr(5'h10, 32'h0);
    tx_write(8'h01, 1'b0); tx_write(8'h02, 1'b0); tx_write(8'h03, 1'b0);
    rd(5'h0C, d); check(!d[13], "R3 not empty", d, 32'h0);
    wr(5'h08, 32'h8000);
    rd(5'h0C, d); check(d[13] && d[6], "R11 tx flush", d, 32'h2040);
    rd(5'h08, d); check(d == 0, "R11 flush bit not stored", d, 0);
    wr(5'h10, 32'd2);
    send_rx(8'h11, 1'b1);
    rd(5'h0C, d); check(d[4], "R11 rx has char", d, 32'h10);
    wr(5'h08, 32'h4000);
    rd(5'h0C, d); check(!d[4], "R11 rx flush", d, 32'h0);

    // R12 soft reset
    wr(5'h14, 32'hFFFF_FFFF);
    rd(5'h14, d); check(d == 32'h3F3F_3F3F, "R12 oversampling mask", d, 32'h3F3F_3F3F);
    wr(5'h08, 32'h3F);
    wr(5'h08, 32'h8000_0000);
    rd(5'h08, d); check(d == 0, "R12 control cleared", d, 0);
    rd(5'h10, d); check(d == 0, "R12 divisor cleared", d, 0);
    rd(5'h14, d); check(d == 32'h3F3F_3F3F, "R12 oversampling kept", d, 32'h3F3F_3F3F);
    rd(5'h0C, d); check(d == 32'h0000_2060, "R12 status reset", d, 32'h0000_2060);

    finish_run();
  end
endmodule